// File: doc/BRIEF.md
# Status-Flag ALU for a 16-bit Microcontroller Datapath

This block is the combinational arithmetic and logic unit of a small 16-bit microcontroller core. Each cycle it takes a source operand, a destination operand, the incoming carry, a byte/word select and a 4-bit operation code. It returns a result and the four status flags negative (N), zero (Z), carry (C) and overflow (V). Instruction decode, operand fetch and the register file sit outside it. The result and the flags are written back by the surrounding core.

The flag rules are not the usual textbook ones. Logical operations report "result nonzero" on C. V has its own meaning for each operation. The unit also contains a packed-BCD adder with a decimal carry-out. That adder leaves V alone, so the unit drives a separate write-enable that tells the core whether V should be updated. In byte mode only the low eight bits take part: the upper result byte is zero, and N, Z, C and V are taken at byte width. The one exception is sign extension, which always works on a full word.

Top module: `nzcv_alu`

## Requirements
- R1: Opcode 0 (AND) gives res = src & dst. C = 1 when res is nonzero, V = 0, N = MSB of res, Z = 1 when res is zero.
- R2: Opcode 1 (XOR) gives res = src ^ dst. C = 1 when res is nonzero. V = 1 only when both operands have their MSB set. N and Z follow res.
- R3: Opcode 2 (INV) gives res = ~dst. C = 1 when res is nonzero. V = MSB of the original dst. N and Z follow res.
- R4: Opcode 3 (TST) gives res = dst, unchanged. N and Z come from dst, C is forced to 1 and V is 0.
- R5: Opcode 4 (RRA) shifts dst right by one place and keeps the MSB. C = old bit 0, V = 0.
- R6: Opcode 5 (RLA) shifts dst left by one place and fills bit 0 with 0. C = old MSB. V = 1 when dst lies in 0x4000..0xBFFF in word mode, or in 0x40..0xBF in byte mode.
- R7: Opcode 6 (SUBC) gives res = dst - src - 1 + cin. C = 1 when no borrow occurs. V = signed overflow of the subtraction.
- R8: Opcode 7 (SXT) copies bit 7 of dst into bits 15..8 and passes bits 7..0 through. It ignores byte_mode. C = 1 when res is nonzero, V = 0, and N = bit 15.
- R9: Opcode 8 (DADD) adds two packed-BCD operands plus cin, with a decimal correction on each digit. C = 1 when the decimal sum exceeds 99 in byte mode or 9999 in word mode. N = MSB of res, Z = 1 when res is zero.
- R10: For DADD, v_we = 0 and v_flag = 0. For opcodes 0 to 7, v_we = 1.
- R11: With byte_mode = 1 (all opcodes except 7), bits 15..8 of res are 0. N is taken from bit 7, and Z, C and V are computed on the low byte.
- R12: Opcodes 9 to 15 pass the active-width dst to res, set C = cin, V = 0 and v_we = 0, and take N and Z from res.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code |
| byte_mode | input | 1 | 1 = byte operands, 0 = word operands |
| src | input | W | Source operand |
| dst | input | W | Destination operand |
| cin | input | 1 | Incoming carry flag |
| res | output | W | Result |
| n_flag | output | 1 | Negative flag |
| z_flag | output | 1 | Zero flag |
| c_flag | output | 1 | Carry flag |
| v_flag | output | 1 | Overflow flag |
| v_we | output | 1 | 1 when the core should write v_flag |

## Verification
The bench builds the unit with the default width W = 16. At that width both the byte lane and the word lane can be driven, so each operation is checked at both the 0x40/0xBF and the 0x4000/0xBFFF boundaries. The same width gives the two-digit and four-digit decimal carry limits (99 and 9999). Directed corner operands are followed by pseudo-random sweeps. Each result is compared against an integer model written from the requirements, and the decimal adder is modelled by converting to and from plain integers.

// File: rtl/nzcv_alu.sv
module nzcv_alu #(
  parameter int W = 16
) (
  input  logic [3:0]   op,
  input  logic         byte_mode,
  input  logic [W-1:0] src,
  input  logic [W-1:0] dst,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         n_flag,
  output logic         z_flag,
  output logic         c_flag,
  output logic         v_flag,
  output logic         v_we
);
  localparam int HB = W / 2;
  localparam int ND = W / 4;
  localparam int HD = HB / 4;

  localparam logic [3:0] OP_AND  = 4'd0;
  localparam logic [3:0] OP_XOR  = 4'd1;
  localparam logic [3:0] OP_INV  = 4'd2;
  localparam logic [3:0] OP_TST  = 4'd3;
  localparam logic [3:0] OP_RRA  = 4'd4;
  localparam logic [3:0] OP_RLA  = 4'd5;
  localparam logic [3:0] OP_SUBC = 4'd6;
  localparam logic [3:0] OP_SXT  = 4'd7;
  localparam logic [3:0] OP_DADD = 4'd8;

  logic [W-1:0] msk, a, b, top_bit, r;
  logic         a_top, b_top, a_nxt, r_top, c, v, vw;
  logic [W:0]   dif;
  logic [W-1:0] dsum;
  logic [ND:0]  dc;
  logic         dcarry, sub_c, sub_v, sub_rtop;

  assign msk     = byte_mode ? {{(W-HB){1'b0}}, {HB{1'b1}}} : {W{1'b1}};
  assign a       = dst & msk;
  assign b       = src & msk;
  assign top_bit = byte_mode ? (W'(1) << (HB-1)) : (W'(1) << (W-1));
  assign a_top   = byte_mode ? a[HB-1] : a[W-1];
  assign b_top   = byte_mode ? b[HB-1] : b[W-1];
  assign a_nxt   = byte_mode ? a[HB-2] : a[W-2];

  assign dif      = {1'b0, a} + {1'b0, ~src & msk} + {{W{1'b0}}, cin};
  assign sub_c    = byte_mode ? dif[HB] : dif[W];
  assign sub_rtop = byte_mode ? dif[HB-1] : dif[W-1];
  assign sub_v    = (a_top != b_top) && (sub_rtop != a_top);

  assign dc[0] = cin;
  for (genvar g = 0; g < ND; g++) begin : g_digit
    logic [4:0] raw;
    logic [4:0] fix;
    assign raw = {1'b0, a[4*g +: 4]} + {1'b0, b[4*g +: 4]} + {4'd0, dc[g]};
    assign fix = raw + 5'd6;
    assign dc[g+1] = raw > 5'd9;
    assign dsum[4*g +: 4] = dc[g+1] ? fix[3:0] : raw[3:0];
  end
  assign dcarry = byte_mode ? dc[HD] : dc[ND];

  always_comb begin
    r  = a;
    c  = 1'b0;
    v  = 1'b0;
    vw = 1'b1;
    case (op)
      OP_AND: begin
        r = a & b;
        c = |r;
      end
      OP_XOR: begin
        r = a ^ b;
        c = |r;
        v = a_top & b_top;
      end
      OP_INV: begin
        r = ~a & msk;
        c = |r;
        v = a_top;
      end
      OP_TST: begin
        r = a;
        c = 1'b1;
      end
      OP_RRA: begin
        r = (a >> 1) | (a_top ? top_bit : '0);
        c = a[0];
      end
      OP_RLA: begin
        r = (a << 1) & msk;
        c = a_top;
        v = a_top ^ a_nxt;
      end
      OP_SUBC: begin
        r = dif[W-1:0] & msk;
        c = sub_c;
        v = sub_v;
      end
      OP_SXT: begin
        r = {{(W-HB){dst[HB-1]}}, dst[HB-1:0]};
        c = |r;
      end
      OP_DADD: begin
        r  = dsum & msk;
        c  = dcarry;
        vw = 1'b0;
      end
      default: begin
        r  = a;
        c  = cin;
        vw = 1'b0;
      end
    endcase
  end

  assign r_top  = (byte_mode && op != OP_SXT) ? r[HB-1] : r[W-1];
  assign res    = r;
  assign n_flag = r_top;
  assign z_flag = (r == '0);
  assign c_flag = c;
  assign v_flag = v;
  assign v_we   = vw;
endmodule

module nzcv_alu_chk #(
  parameter int W = 16
) (
  input logic [3:0]   op,
  input logic         byte_mode,
  input logic [W-1:0] src,
  input logic [W-1:0] dst,
  input logic         cin,
  input logic [W-1:0] res,
  input logic         n_flag,
  input logic         z_flag,
  input logic         c_flag,
  input logic         v_flag,
  input logic         v_we
);
  localparam int HB = W / 2;
  logic [W-1:0] m;
  assign m = byte_mode ? {{(W-HB){1'b0}}, {HB{1'b1}}} : {W{1'b1}};

  always_comb begin
    if (!$isunknown({op, byte_mode, src, dst, cin})) begin
      if (op == 4'd0)
        p_and_value_r1: assert (res == (src & dst & m) && !v_flag)
          else $error("AND result or V wrong");
      if (op == 4'd3)
        p_tst_keeps_r4: assert (res == (dst & m) && c_flag && !v_flag &&
                                z_flag == ((dst & m) == '0) &&
                                n_flag == (byte_mode ? dst[HB-1] : dst[W-1]))
          else $error("TST altered operand or flags");
      if (op == 4'd4 && !byte_mode)
        p_rra_sign_r5: assert (res[W-1] == dst[W-1] && c_flag == dst[0])
          else $error("RRA sign or carry wrong");
      if (op == 4'd7)
        p_sxt_fill_r8: assert (res[W-1:HB] == {(W-HB){dst[HB-1]}})
          else $error("SXT fill wrong");
      if (op == 4'd8)
        p_dadd_vhold_r10: assert (!v_we && !v_flag)
          else $error("DADD touched V");
      if (byte_mode && op != 4'd7)
        p_byte_upper_r11: assert (res[W-1:HB] == '0)
          else $error("byte mode upper byte not clear");
      if (op > 4'd8)
        p_undef_pass_r12: assert (c_flag == cin && !v_we && res == (dst & m))
          else $error("unassigned opcode misbehaved");
    end
  end
endmodule

bind nzcv_alu nzcv_alu_chk #(.W(W)) u_chk (
  .op(op), .byte_mode(byte_mode), .src(src), .dst(dst), .cin(cin),
  .res(res), .n_flag(n_flag), .z_flag(z_flag), .c_flag(c_flag),
  .v_flag(v_flag), .v_we(v_we)
);

// File: tb/sim_nzcv_alu.sv
module sim_nzcv_alu;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [3:0]   op_i = '0;
  logic         bw_i = 1'b0;
  logic [W-1:0] src_i = '0, dst_i = '0;
  logic         cin_i = 1'b0;
  logic [W-1:0] res_o;
  logic         n_o, z_o, c_o, v_o, we_o;

  int ntests = 0;
  int nfail  = 0;
  bit done   = 1'b0;

  nzcv_alu #(.W(W)) u0 (
    .op(op_i), .byte_mode(bw_i), .src(src_i), .dst(dst_i), .cin(cin_i),
    .res(res_o), .n_flag(n_o), .z_flag(z_o), .c_flag(c_o), .v_flag(v_o), .v_we(we_o)
  );

  function automatic int bcd2int(input logic [15:0] x);
    int acc = 0;
    for (int i = 3; i >= 0; i--) acc = acc * 10 + int'(x[4*i +: 4]);
    return acc;
  endfunction

  function automatic logic [15:0] int2bcd(input int x);
    logic [15:0] y = '0;
    int t = x;
    for (int i = 0; i < 4; i++) begin
      y[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return y;
  endfunction

  task automatic model(input logic [3:0] o, input logic bw, input logic [15:0] s, d,
                       input logic ci, output logic [15:0] r, output logic n, z, c, v, we);
    int tw, tp, t, sa, sb, st, lim;
    logic [15:0] m, a, b;
    tw = bw ? 8 : 16;
    tp = tw - 1;
    m  = bw ? 16'h00FF : 16'hFFFF;
    a  = d & m;
    b  = s & m;
    v  = 1'b0;
    we = (o <= 4'd7);
    case (o)
      4'd0: begin r = a & b; c = (r != 0); end
      4'd1: begin r = a ^ b; c = (r != 0); v = a[tp] & b[tp]; end
      4'd2: begin r = ~a & m; c = (r != 0); v = a[tp]; end
      4'd3: begin r = a; c = 1'b1; end
      4'd4: begin r = (a >> 1) | (a & (16'd1 << tp)); c = a[0]; end
      4'd5: begin
        r = (a << 1) & m; c = a[tp];
        v = bw ? (a >= 16'h40 && a < 16'hC0) : (a >= 16'h4000 && a < 16'hC000);
      end
      4'd6: begin
        t  = int'(a) - int'(b) - 1 + int'(ci);
        r  = 16'(t) & m;
        c  = (t >= 0);
        sa = a[tp] ? int'(a) - (1 << tw) : int'(a);
        sb = b[tp] ? int'(b) - (1 << tw) : int'(b);
        st = sa - sb - 1 + int'(ci);
        v  = (st < -(1 << (tw - 1))) || (st >= (1 << (tw - 1)));
      end
      4'd7: begin r = {{8{d[7]}}, d[7:0]}; c = (r != 0); tp = 15; end
      4'd8: begin
        lim = bw ? 99 : 9999;
        t = bcd2int(a) + bcd2int(b) + int'(ci);
        c = (t > lim);
        r = int2bcd(t % (lim + 1)) & m;
      end
      default: begin r = a; c = ci; end
    endcase
    n = r[tp];
    z = (r == 0);
  endtask

  task automatic apply(input logic [3:0] o, input logic bw, input logic [15:0] s, d,
                       input logic ci, input string tag);
    logic [15:0] er;
    logic en, ez, ec, ev, ew;
    @(negedge clk);
    op_i = o; bw_i = bw; src_i = s; dst_i = d; cin_i = ci;
    #2;
    model(o, bw, s, d, ci, er, en, ez, ec, ev, ew);
    ntests++;
    if (res_o !== er || n_o !== en || z_o !== ez || c_o !== ec || v_o !== ev || we_o !== ew) begin
      nfail++;
      $display("FAIL %s op=%0d bw=%0d src=%h dst=%h cin=%0d: got res=%h nzcv=%b%b%b%b we=%b, exp res=%h nzcv=%b%b%b%b we=%b",
               tag, o, bw, s, d, ci, res_o, n_o, z_o, c_o, v_o, we_o, er, en, ez, ec, ev, ew);
    end
  endtask

  logic [31:0] seed = 32'h1234_5678;
  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  task automatic t_reset();
    apply(4'd0, 1'b0, 16'h0000, 16'h0000, 1'b0, "R1 reset");
  endtask

  task automatic t_logic();
    apply(4'd0, 1'b0, 16'hF0F0, 16'h0FF0, 1'b0, "R1");
    apply(4'd0, 1'b0, 16'hFF00, 16'h00FF, 1'b1, "R1");
    apply(4'd1, 1'b0, 16'h8001, 16'h8000, 1'b0, "R2");
    apply(4'd1, 1'b0, 16'h8001, 16'h7000, 1'b0, "R2");
    apply(4'd1, 1'b0, 16'h1234, 16'h1234, 1'b0, "R2");
    apply(4'd2, 1'b0, 16'h0000, 16'h8000, 1'b0, "R3");
    apply(4'd2, 1'b0, 16'h0000, 16'hFFFF, 1'b1, "R3");
    apply(4'd2, 1'b0, 16'h0000, 16'h0001, 1'b0, "R3");
  endtask

  task automatic t_tst();
    apply(4'd3, 1'b0, 16'hFFFF, 16'h0000, 1'b0, "R4");
    apply(4'd3, 1'b0, 16'h0000, 16'h8123, 1'b0, "R4");
    apply(4'd3, 1'b1, 16'h0000, 16'h7F80, 1'b0, "R4");
  endtask

  task automatic t_shift();
    apply(4'd4, 1'b0, 16'h0, 16'h8001, 1'b0, "R5");
    apply(4'd4, 1'b0, 16'h0, 16'h4002, 1'b1, "R5");
    apply(4'd4, 1'b1, 16'h0, 16'h1281, 1'b0, "R5");
    apply(4'd5, 1'b0, 16'h0, 16'h3FFF, 1'b0, "R6");
    apply(4'd5, 1'b0, 16'h0, 16'h4000, 1'b0, "R6");
    apply(4'd5, 1'b0, 16'h0, 16'hBFFF, 1'b0, "R6");
    apply(4'd5, 1'b0, 16'h0, 16'hC000, 1'b0, "R6");
    apply(4'd5, 1'b1, 16'h0, 16'h003F, 1'b0, "R6");
    apply(4'd5, 1'b1, 16'h0, 16'h0040, 1'b0, "R6");
    apply(4'd5, 1'b1, 16'h0, 16'h00BF, 1'b0, "R6");
    apply(4'd5, 1'b1, 16'h0, 16'h00C0, 1'b0, "R6");
  endtask

  task automatic t_subc();
    apply(4'd6, 1'b0, 16'h0003, 16'h0005, 1'b1, "R7");
    apply(4'd6, 1'b0, 16'h0005, 16'h0003, 1'b1, "R7");
    apply(4'd6, 1'b0, 16'h0003, 16'h0003, 1'b0, "R7");
    apply(4'd6, 1'b0, 16'h0001, 16'h8000, 1'b1, "R7");
    apply(4'd6, 1'b0, 16'hFFFF, 16'h7FFF, 1'b1, "R7");
    apply(4'd6, 1'b1, 16'h0001, 16'h0080, 1'b1, "R7");
    apply(4'd6, 1'b1, 16'hAA10, 16'h5510, 1'b1, "R7");
    for (int i = 0; i < 40; i++) begin
      seed = nxt(seed);
      apply(4'd6, seed[0], seed[31:16], seed[15:0], seed[1], "R7 sweep");
    end
  endtask

  task automatic t_sxt();
    apply(4'd7, 1'b0, 16'h0, 16'h1280, 1'b0, "R8");
    apply(4'd7, 1'b1, 16'h0, 16'hFF7F, 1'b0, "R8");
    apply(4'd7, 1'b1, 16'h0, 16'hAB00, 1'b1, "R8");
  endtask

  task automatic t_dadd();
    apply(4'd8, 1'b0, 16'h1234, 16'h4321, 1'b0, "R9");
    apply(4'd8, 1'b0, 16'h0009, 16'h0001, 1'b0, "R9");
    apply(4'd8, 1'b0, 16'h9999, 16'h0000, 1'b1, "R9");
    apply(4'd8, 1'b0, 16'h5000, 16'h4999, 1'b0, "R9");
    apply(4'd8, 1'b1, 16'h0099, 16'h0000, 1'b1, "R9");
    apply(4'd8, 1'b1, 16'h0049, 16'h0050, 1'b0, "R9");
    apply(4'd8, 1'b1, 16'h0045, 16'h0055, 1'b0, "R10");
    for (int i = 0; i < 40; i++) begin
      seed = nxt(seed);
      apply(4'd8, seed[2], int2bcd(int'(seed[31:16]) % 10000),
            int2bcd(int'(seed[15:0]) % 10000), seed[3], "R9 sweep");
    end
  endtask

  task automatic t_bytemode();
    apply(4'd0, 1'b1, 16'hFF80, 16'hFFC0, 1'b0, "R11");
    apply(4'd1, 1'b1, 16'h0080, 16'h0080, 1'b0, "R11");
    apply(4'd2, 1'b1, 16'h1234, 16'h00FF, 1'b0, "R11");
    apply(4'd2, 1'b1, 16'h0000, 16'h1280, 1'b0, "R11");
    for (int o = 0; o < 8; o++) begin
      seed = nxt(seed);
      apply(4'(o), 1'b1, seed[31:16], seed[15:0], seed[4], "R11 sweep");
      apply(4'(o), 1'b0, seed[15:0], seed[31:16], seed[5], "R10 sweep");
    end
  endtask

  task automatic t_undef();
    apply(4'd9,  1'b0, 16'h1111, 16'hABCD, 1'b1, "R12");
    apply(4'd15, 1'b1, 16'h1111, 16'hAB00, 1'b0, "R12");
    apply(4'd12, 1'b1, 16'h0000, 16'h5580, 1'b1, "R12");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_logic();
    t_tst();
    t_shift();
    t_subc();
    t_sxt();
    t_dadd();
    t_bytemode();
    t_undef();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done && !rst) begin
      done = 1'b1;
      ntests++;
      nfail++;
      $display("FAIL watchdog: run did not finish, got timeout, exp completion");
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end
endmodule